// File: doc/BRIEF.md
# Direct-Mapped Translation Fast-Path Lookup

This block holds a small direct-mapped table of recent linear-to-physical page translations and decides, for each load, store or read-modify-write issued in 64-bit mode, whether the access can complete on the fast path. A request carries a 64-bit linear address, an access width, an access kind, the current privilege level (optionally replaced by a separately supplied level for stack pushes during a privilege switch) and an alignment-check mask. One cycle later the block reports whether the access hit and was permitted, the physical address, and a page-write pulse for the code-invalidation logic.

The set is picked from the page number of the last byte of the access, so an access that spills into the next page looks in the wrong set and cannot match. Alignment-relevant low address bits are folded into the compared key, so a misaligned access that must fault never hits. A fill port installs entries, and a flush input invalidates every entry at once. Page walking, the slow path and fault generation live elsewhere.

Top module: `tlb_fastpath`

## Requirements
- R1: After reset every entry is invalid; `rsp_valid_o`, `hit_o` and `page_wr_o` are low until a request is made and no lookup hits before a fill.
- R2: A request presented with `req_i` high at a clock edge is answered one cycle later: `rsp_valid_o` is high for that one cycle and the outputs describe that request.
- R3: The set index is bits [17:12] of (address + width - 1); a fill stores its entry in the set given by bits [5:0] of its page number. An access whose last byte lies in the following page therefore misses.
- R4: A hit needs a valid entry whose stored page number equals address bits [63:12]; on a hit `paddr_o` is the stored 40-bit physical frame followed by address bits [11:0].
- R5: Width codes are 0=1, 1=2, 2=4, 3=8, 4=16 bytes. For codes 1 to 3, address bits [3:0] ANDed with (width - 1) and with `ac_mask_i` must be zero for a hit.
- R6: For width code 4 with `align16_i` high, address bits [3:0] must be zero for a hit; with `align16_i` low, and for width code 0, the low address bits play no part in the match.
- R7: Permission bit 0 denies user access: a read (kind 0) is refused when bit 0 is set and the effective privilege level is 3.
- R8: A write (kind 1) or read-modify-write (kind 2) is refused when permission bit 1 (write deny) is set, or when bit 0 is set and the effective privilege level is 3.
- R9: `page_wr_o` is high exactly when a write or read-modify-write hits; a read never raises it.
- R10: With `use_alt_pl_i` high the effective privilege level is `alt_pl_i`, otherwise `cpl_i`.
- R11: A fill writes its entry at the clock edge where `fill_en_i` is high; a lookup presented at that same edge sees the contents from before the fill, later lookups see the new entry.
- R12: A flush invalidates every entry at its edge; a lookup at the same edge sees the old valid state, and a fill at the same edge as a flush leaves its entry invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Lookup request strobe |
| addr_i | input | 64 | Linear address of the first byte |
| size_i | input | 3 | Width code (0..4 = 1..16 bytes) |
| kind_i | input | 2 | 0 read, 1 write, 2 read-modify-write |
| align16_i | input | 1 | 16-byte access must be naturally aligned |
| ac_mask_i | input | 4 | Alignment-check mask |
| cpl_i | input | 2 | Current privilege level |
| use_alt_pl_i | input | 1 | Use `alt_pl_i` for the user check |
| alt_pl_i | input | 2 | Substitute privilege level |
| fill_en_i | input | 1 | Write an entry |
| fill_lpf_i | input | 52 | Linear page number of the new entry |
| fill_ppf_i | input | 40 | Physical frame of the new entry |
| fill_perm_i | input | 2 | Deny bits: [1] write deny, [0] user deny |
| flush_i | input | 1 | Invalidate all entries |
| rsp_valid_o | output | 1 | Response for last cycle's request |
| hit_o | output | 1 | Fast path allowed |
| paddr_o | output | 52 | Physical address (meaningful on hit) |
| page_wr_o | output | 1 | Fast-path write to the physical page in `paddr_o` |

## Verification
The lookup and table maintenance share the clock edge, so a fill or a flush can land in the same cycle as a lookup of the very set it touches. The bench provokes this by issuing a lookup of an installed page while overwriting that set with a different page, and again while flushing, and it also fires a flush together with a fill. It judges each case against a bench-side table model: the coincident lookup must reflect the table from before the edge, and the following lookups must reflect the new entry, an empty table, or a still-invalid entry respectively.

// File: rtl/tlb_fp_pkg.sv
package tlb_fp_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_RMW   = 2'd2
  } acc_kind_e;

  localparam int PERM_W    = 2;
  localparam int WDENY_BIT = 1;
  localparam int UDENY_BIT = 0;

  // width code -> byte count minus one
  function automatic logic [4:0] size_minus1(input logic [2:0] code);
    case (code)
      3'd0:    return 5'd0;
      3'd1:    return 5'd1;
      3'd2:    return 5'd3;
      3'd3:    return 5'd7;
      default: return 5'd15;
    endcase
  endfunction

endpackage

// File: rtl/tlb_fp_keygen.sv
module tlb_fp_keygen
  import tlb_fp_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 6
) (
  input  logic [VA_W-1:0]           addr,
  input  logic [2:0]                size_code,
  input  logic                      align16,
  input  logic [3:0]                ac_mask,
  output logic [IDX_W-1:0]          idx,
  output logic [VA_W-PAGE_BITS-1:0] lpf,
  output logic [3:0]                low_key
);
  logic [4:0]      span;
  logic [VA_W-1:0] last_byte;

  always_comb begin
    span      = size_minus1(size_code);
    last_byte = addr + VA_W'(span);
    idx       = last_byte[PAGE_BITS +: IDX_W];
    lpf       = addr[VA_W-1:PAGE_BITS];
    case (size_code)
      3'd1, 3'd2, 3'd3: low_key = addr[3:0] & span[3:0] & ac_mask;
      3'd4:             low_key = align16 ? addr[3:0] : 4'd0;
      default:          low_key = 4'd0;
    endcase
  end
endmodule

// File: rtl/tlb_fp_store.sv
module tlb_fp_store
  import tlb_fp_pkg::*;
#(
  parameter int LPF_W = 52,
  parameter int PPF_W = 40,
  parameter int IDX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en_i,
  input  logic [LPF_W-1:0]  fill_lpf_i,
  input  logic [PPF_W-1:0]  fill_ppf_i,
  input  logic [PERM_W-1:0] fill_perm_i,
  input  logic              flush_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_vld_o,
  output logic [LPF_W-1:0]  rd_tag_o,
  output logic [PPF_W-1:0]  rd_ppf_o,
  output logic [PERM_W-1:0] rd_perm_o
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int WORD_W  = LPF_W + PPF_W + PERM_W;

  logic [WORD_W-1:0]  mem [ENTRIES];
  logic [WORD_W-1:0]  rd_word;
  logic [ENTRIES-1:0] valid_q;
  logic [IDX_W-1:0]   wr_idx;

  assign wr_idx = fill_lpf_i[IDX_W-1:0];

  // block-RAM style: write port, registered read-before-write port
  always_ff @(posedge clk) begin
    if (fill_en_i) mem[wr_idx] <= {fill_lpf_i, fill_ppf_i, fill_perm_i};
    rd_word <= mem[rd_idx_i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      rd_vld_o <= valid_q[rd_idx_i];
      if (flush_i)        valid_q         <= '0;
      else if (fill_en_i) valid_q[wr_idx] <= 1'b1;
    end
  end

  assign {rd_tag_o, rd_ppf_o, rd_perm_o} = rd_word;

  // R12
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (valid_q == '0));

  // R11
  fill_set_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en_i && !flush_i) |=> valid_q[$past(fill_lpf_i[IDX_W-1:0])]);
endmodule

// File: rtl/tlb_fp_grant.sv
module tlb_fp_grant
  import tlb_fp_pkg::*;
(
  input  logic [PERM_W-1:0] perm_i,
  input  logic              is_wr_i,
  input  logic              is_user_i,
  output logic              allow_o
);
  logic user_block;
  logic write_block;

  always_comb begin
    user_block  = perm_i[UDENY_BIT] && is_user_i;
    write_block = perm_i[WDENY_BIT] && is_wr_i;
    allow_o     = !user_block && !write_block;
  end
endmodule

// File: rtl/tlb_fastpath.sv
module tlb_fastpath
  import tlb_fp_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PA_W      = 52,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_i,
  input  logic [VA_W-1:0]             addr_i,
  input  logic [2:0]                  size_i,
  input  logic [1:0]                  kind_i,
  input  logic                        align16_i,
  input  logic [3:0]                  ac_mask_i,
  input  logic [1:0]                  cpl_i,
  input  logic                        use_alt_pl_i,
  input  logic [1:0]                  alt_pl_i,
  input  logic                        fill_en_i,
  input  logic [VA_W-PAGE_BITS-1:0]   fill_lpf_i,
  input  logic [PA_W-PAGE_BITS-1:0]   fill_ppf_i,
  input  logic [1:0]                  fill_perm_i,
  input  logic                        flush_i,
  output logic                        rsp_valid_o,
  output logic                        hit_o,
  output logic [PA_W-1:0]             paddr_o,
  output logic                        page_wr_o
);
  localparam int LPF_W = VA_W - PAGE_BITS;
  localparam int PPF_W = PA_W - PAGE_BITS;

  logic [IDX_W-1:0]     look_idx;
  logic [LPF_W-1:0]     look_lpf;
  logic [3:0]           look_low;
  logic [1:0]           eff_pl;
  logic                 want_wr;

  logic                 rsp_q, wr_q, user_q;
  logic [LPF_W-1:0]     lpf_q;
  logic [3:0]           low_q;
  logic [PAGE_BITS-1:0] off_q;

  logic                 rd_vld;
  logic [LPF_W-1:0]     rd_tag;
  logic [PPF_W-1:0]     rd_ppf;
  logic [PERM_W-1:0]    rd_perm;
  logic                 tag_match, allow;

  tlb_fp_keygen #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_keygen (
    .addr(addr_i), .size_code(size_i), .align16(align16_i), .ac_mask(ac_mask_i),
    .idx(look_idx), .lpf(look_lpf), .low_key(look_low)
  );

  tlb_fp_store #(.LPF_W(LPF_W), .PPF_W(PPF_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .fill_en_i(fill_en_i), .fill_lpf_i(fill_lpf_i), .fill_ppf_i(fill_ppf_i),
    .fill_perm_i(fill_perm_i), .flush_i(flush_i), .rd_idx_i(look_idx),
    .rd_vld_o(rd_vld), .rd_tag_o(rd_tag), .rd_ppf_o(rd_ppf), .rd_perm_o(rd_perm)
  );

  assign eff_pl  = use_alt_pl_i ? alt_pl_i : cpl_i;
  assign want_wr = (kind_i == ACC_WRITE) || (kind_i == ACC_RMW);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q  <= 1'b0;
      wr_q   <= 1'b0;
      user_q <= 1'b0;
      lpf_q  <= '0;
      low_q  <= '0;
      off_q  <= '0;
    end else begin
      rsp_q  <= req_i;
      wr_q   <= want_wr;
      user_q <= (eff_pl == 2'd3);
      lpf_q  <= look_lpf;
      low_q  <= look_low;
      off_q  <= addr_i[PAGE_BITS-1:0];
    end
  end

  assign tag_match = rd_vld && (rd_tag == lpf_q) && (low_q == 4'd0);

  tlb_fp_grant u_grant (
    .perm_i(rd_perm), .is_wr_i(wr_q), .is_user_i(user_q), .allow_o(allow)
  );

  assign rsp_valid_o = rsp_q;
  assign hit_o       = rsp_q && tag_match && allow;
  assign paddr_o     = {rd_ppf, off_q};
  assign page_wr_o   = hit_o && wr_q;

  // checker-side views of the request, computed apart from the datapath
  logic [4:0]         chk_span;
  logic [PAGE_BITS:0] chk_end;
  logic               chk_cross;
  logic               chk_misal;
  assign chk_span  = size_minus1(size_i);
  assign chk_end   = {1'b0, addr_i[PAGE_BITS-1:0]} + (PAGE_BITS+1)'(chk_span);
  assign chk_cross = chk_end[PAGE_BITS];
  assign chk_misal = (size_i == 3'd1 || size_i == 3'd2 || size_i == 3'd3) &&
                     ((addr_i[3:0] & chk_span[3:0] & ac_mask_i) != 4'd0);

  // R2
  rsp_lat_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> rsp_valid_o);

  // R3
  cross_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && chk_cross) |=> !hit_o);

  // R5
  misalign_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && chk_misal) |=> !hit_o);

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
    req_i |=> (paddr_o[PAGE_BITS-1:0] == $past(addr_i[PAGE_BITS-1:0])));

  // R9
  read_no_pgwr_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && kind_i == ACC_READ) |=> !page_wr_o);

  // R7
  user_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_i && eff_pl == 2'd3) |=> (!hit_o || !rd_perm[UDENY_BIT]));
endmodule

// File: tb/tlb_fastpath_bench.sv
module tlb_fastpath_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_i;
  logic [63:0] addr_i;
  logic [2:0]  size_i;
  logic [1:0]  kind_i;
  logic        align16_i;
  logic [3:0]  ac_mask_i;
  logic [1:0]  cpl_i;
  logic        use_alt_pl_i;
  logic [1:0]  alt_pl_i;
  logic        fill_en_i;
  logic [51:0] fill_lpf_i;
  logic [39:0] fill_ppf_i;
  logic [1:0]  fill_perm_i;
  logic        flush_i;
  logic        rsp_valid_o, hit_o, page_wr_o;
  logic [51:0] paddr_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic        m_vld  [64];
  logic [51:0] m_tag  [64];
  logic [39:0] m_ppf  [64];
  logic [1:0]  m_perm [64];

  localparam logic [45:0] HI_A = 46'h0123_4567_89AB;
  localparam logic [45:0] HI_B = 46'h2AAA_5555_1234;

  always #5 clk = ~clk;

  tlb_fastpath u_tlb_fastpath (
    .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i), .size_i(size_i),
    .kind_i(kind_i), .align16_i(align16_i), .ac_mask_i(ac_mask_i), .cpl_i(cpl_i),
    .use_alt_pl_i(use_alt_pl_i), .alt_pl_i(alt_pl_i), .fill_en_i(fill_en_i),
    .fill_lpf_i(fill_lpf_i), .fill_ppf_i(fill_ppf_i), .fill_perm_i(fill_perm_i),
    .flush_i(flush_i), .rsp_valid_o(rsp_valid_o), .hit_o(hit_o),
    .paddr_o(paddr_o), .page_wr_o(page_wr_o)
  );

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    req_i = 0; fill_en_i = 0; flush_i = 0;
  endtask

  task automatic set_req(input logic [63:0] a, input logic [2:0] sz, input logic al,
                         input logic [1:0] kd, input logic [3:0] ac,
                         input logic [1:0] cpl, input logic ua, input logic [1:0] apl);
    req_i = 1; addr_i = a; size_i = sz; align16_i = al; kind_i = kd;
    ac_mask_i = ac; cpl_i = cpl; use_alt_pl_i = ua; alt_pl_i = apl;
  endtask

  task automatic set_fill(input logic [51:0] lpf, input logic [39:0] ppf,
                          input logic [1:0] perm);
    fill_en_i = 1; fill_lpf_i = lpf; fill_ppf_i = ppf; fill_perm_i = perm;
  endtask

  function automatic logic [39:0] ppf_of(input int i);
    return 40'hC0_0000_0000 | (40'(i) * 40'h0001_0203);
  endfunction

  // reference result from the requirements, using the bench table model
  function automatic void predict(input logic [63:0] a, input logic [2:0] sz,
                                  input logic al, input logic [1:0] kd,
                                  input logic [3:0] ac, input logic [1:0] pl,
                                  output logic hit, output logic [51:0] pa,
                                  output logic pwr);
    logic [63:0] nb1, last;
    logic [5:0]  ix;
    logic [3:0]  low;
    logic        found, user, okr, okw, wr;
    nb1  = (64'd1 << sz) - 64'd1;
    last = a + nb1;
    ix   = last[17:12];
    if (sz >= 3'd1 && sz <= 3'd3) low = a[3:0] & nb1[3:0] & ac;
    else if (sz == 3'd4 && al)    low = a[3:0];
    else                          low = 4'd0;
    found = m_vld[ix] && (m_tag[ix] == a[63:12]) && (low == 4'd0);
    user  = (pl == 2'd3);
    okr   = !(m_perm[ix][0] && user);
    okw   = okr && !m_perm[ix][1];
    wr    = (kd == 2'd1) || (kd == 2'd2);
    hit   = found && (wr ? okw : okr);
    pa    = {m_ppf[ix], a[11:0]};
    pwr   = hit && wr;
  endfunction

  task automatic lookup_chk(input string tag, input logic [63:0] a, input logic [2:0] sz,
                            input logic al, input logic [1:0] kd, input logic [3:0] ac,
                            input logic [1:0] cpl, input logic ua, input logic [1:0] apl);
    logic eh, ep; logic [51:0] epa;
    predict(a, sz, al, kd, ac, ua ? apl : cpl, eh, epa, ep);
    set_req(a, sz, al, kd, ac, cpl, ua, apl);
    step();
    idle();
    chk("R2", "rsp_valid", 64'(rsp_valid_o), 64'd1);
    chk(tag, "hit/paddr", {11'd0, hit_o, hit_o ? paddr_o : 52'd0},
        {11'd0, eh, eh ? epa : 52'd0});
    chk("R9", "page_wr", 64'(page_wr_o), 64'(ep));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [11:0] offs [7];
    offs = '{12'h000, 12'h001, 12'h006, 12'h7F8, 12'hFF0, 12'hFFC, 12'hFFF};
    for (int i = 0; i < 64; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_ppf[i] = '0; m_perm[i] = '0;
    end
    rst = 1; idle();
    addr_i = '0; size_i = '0; kind_i = '0; align16_i = 0; ac_mask_i = '0;
    cpl_i = '0; use_alt_pl_i = 0; alt_pl_i = '0;
    fill_lpf_i = '0; fill_ppf_i = '0; fill_perm_i = '0;
    repeat (3) step();
    rst = 0;
    step();

    // R1: reset state and empty table
    chk("R1", "rsp_valid idle", 64'(rsp_valid_o), 64'd0);
    chk("R1", "hit idle", 64'(hit_o), 64'd0);
    for (int i = 0; i < 64; i++)
      lookup_chk("R1", {HI_A, 6'(i), 12'h100}, 3'd0, 1'b0, 2'd0, 4'd0, 2'd0, 1'b0, 2'd0);
    step();
    chk("R2", "rsp_valid after idle", 64'(rsp_valid_o), 64'd0);

    // R3/R11: fill every set, index taken from the page number
    for (int i = 0; i < 64; i++) begin
      set_fill({HI_A, 6'(i)}, ppf_of(i), 2'(i % 4));
      step();
      idle();
      m_vld[i] = 1; m_tag[i] = {HI_A, 6'(i)}; m_ppf[i] = ppf_of(i); m_perm[i] = 2'(i % 4);
    end

    // main sweep: sets x offsets x widths x alignment x kinds x levels x masks
    for (int i = 0; i < 64; i++)
      for (int o = 0; o < 7; o++)
        for (int sz = 0; sz < 5; sz++)
          for (int al = 0; al < 2; al++)
            for (int kd = 0; kd < 3; kd++)
              for (int pl = 0; pl < 2; pl++)
                for (int ac = 0; ac < 2; ac++) begin
                  logic [63:0] a;
                  logic [63:0] nb1;
                  logic [63:0] last;
                  logic [3:0]  low;
                  string tg;
                  a    = {HI_A, 6'(i), offs[o]};
                  nb1  = (64'd1 << sz) - 64'd1;
                  last = a + nb1;
                  low  = a[3:0] & nb1[3:0] & (ac != 0 ? 4'hF : 4'h0);
                  if (last[63:12] != a[63:12])             tg = "R3";
                  else if (sz >= 1 && sz <= 3 && low != 0) tg = "R5";
                  else if (sz == 4 || sz == 0)             tg = "R6";
                  else if (kd != 0)                        tg = "R8";
                  else if (pl != 0)                        tg = "R7";
                  else                                     tg = "R4";
                  lookup_chk(tg, a, 3'(sz), 1'(al), 2'(kd), ac != 0 ? 4'hF : 4'h0,
                             pl != 0 ? 2'd3 : 2'd0, 1'b0, 2'd0);
                end

    // R4: same set, different upper page bits must miss
    for (int i = 0; i < 64; i++)
      lookup_chk("R4", {HI_B, 6'(i), 12'h040}, 3'd0, 1'b0, 2'd0, 4'd0, 2'd0, 1'b0, 2'd0);

    // R10: substitute privilege level
    for (int i = 0; i < 4; i++)
      for (int c = 0; c < 4; c++)
        for (int p = 0; p < 4; p++)
          for (int u = 0; u < 2; u++)
            for (int kd = 0; kd < 3; kd++)
              lookup_chk("R10", {HI_A, 6'(i), 12'h020}, 3'd2, 1'b0, 2'(kd), 4'hF,
                         2'(c), 1'(u), 2'(p));

    // R11: lookup and overwrite of the same set at the same edge
    begin
      logic eh, ep; logic [51:0] epa;
      predict({HI_A, 6'd5, 12'h010}, 3'd0, 1'b0, 2'd0, 4'd0, 2'd0, eh, epa, ep);
      set_req({HI_A, 6'd5, 12'h010}, 3'd0, 1'b0, 2'd0, 4'd0, 2'd0, 1'b0, 2'd0);
      set_fill({HI_B, 6'd5}, 40'h12_3456_789A, 2'd0);
      step();
      idle();
      chk("R11", "same-edge lookup sees old entry", {11'd0, hit_o, paddr_o}, {11'd0, eh, epa});
      m_tag[5] = {HI_B, 6'd5}; m_ppf[5] = 40'h12_3456_789A; m_perm[5] = 2'd0;
      lookup_chk("R11", {HI_B, 6'd5, 12'h010}, 3'd3, 1'b0, 2'd1, 4'hF, 2'd3, 1'b0, 2'd0);
      lookup_chk("R11", {HI_A, 6'd5, 12'h010}, 3'd0, 1'b0, 2'd0, 4'd0, 2'd0, 1'b0, 2'd0);
    end

    // R12: flush coinciding with a lookup, then an empty table
    begin
      logic eh, ep; logic [51:0] epa;
      predict({HI_A, 6'd7, 12'h200}, 3'd1, 1'b0, 2'd0, 4'hF, 2'd0, eh, epa, ep);
      set_req({HI_A, 6'd7, 12'h200}, 3'd1, 1'b0, 2'd0, 4'hF, 2'd0, 1'b0, 2'd0);
      flush_i = 1;
      step();
      idle();
      chk("R12", "same-edge lookup sees old valid", {11'd0, hit_o, paddr_o}, {11'd0, eh, epa});
      for (int i = 0; i < 64; i++) m_vld[i] = 0;
      for (int i = 0; i < 64; i++)
        lookup_chk("R12", {HI_A, 6'(i), 12'h200}, 3'd0, 1'b0, 2'd0, 4'd0, 2'd0, 1'b0, 2'd0);
      lookup_chk("R12", {HI_B, 6'd5, 12'h010}, 3'd0, 1'b0, 2'd0, 4'd0, 2'd0, 1'b0, 2'd0);
    end

    // R12: flush beats a fill at the same edge; R11: a lone fill then lands
    set_fill({HI_A, 6'd9}, ppf_of(9), 2'd0);
    flush_i = 1;
    step();
    idle();
    lookup_chk("R12", {HI_A, 6'd9, 12'h008}, 3'd0, 1'b0, 2'd0, 4'd0, 2'd0, 1'b0, 2'd0);
    set_fill({HI_A, 6'd9}, ppf_of(9), 2'd0);
    step();
    idle();
    m_vld[9] = 1; m_tag[9] = {HI_A, 6'd9}; m_ppf[9] = ppf_of(9); m_perm[9] = 2'd0;
    lookup_chk("R11", {HI_A, 6'd9, 12'h008}, 3'd3, 1'b0, 2'd2, 4'hF, 2'd3, 1'b0, 2'd0);
    lookup_chk("R6", {HI_A, 6'd9, 12'h008}, 3'd4, 1'b1, 2'd0, 4'd0, 2'd0, 1'b0, 2'd0);
    lookup_chk("R6", {HI_A, 6'd9, 12'h008}, 3'd4, 1'b0, 2'd0, 4'd0, 2'd0, 1'b0, 2'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule